// File: doc/BRIEF.md
# Serial Bitstream Configuration Loader

This block configures a downstream programmable device through a slave-serial link. A start request powers the target, waits for its supply to settle, holds the target's active-low program line low for a fixed interval, then releases it. After that the loader reads a fixed-length image from a memory read port, one 32-bit word at a time, and shifts each word out MSB first. Every bit gets exactly one configuration-clock pulse.

Each bit uses two system-clock cycles. In the first, the data line takes the new bit while the clock is low. In the second, the clock is high. The memory port has one cycle of read latency. The next word is requested while the last bit of the current word is on the line, so the serial stream has no gaps between words. A busy flag covers the whole sequence. A one-cycle done pulse follows the final clock pulse. All delays are parameters counted in system-clock cycles.

Top module: `cfg_stream_loader`

## Requirements
- R1: After reset: power enable is 0, the program line is 1, the configuration clock is 0, the data line is 0, busy is 0, done is 0 and no read is issued.
- R2: When start is sampled high while idle, power enable and busy are 1 from the next cycle on. Power enable then stays 1 for the whole sequence and after it.
- R3: The program line falls exactly PWR_WAIT_CYC + PRE_PROG_CYC cycles after the edge that accepts start. Until then the program line is 1 and the configuration clock and data line are both 0.
- R4: The program line stays low for exactly PROG_LOW_CYC cycles. The configuration clock is 0 the whole time.
- R5: Each bit takes one cycle with the clock low and the data line set, then one cycle with the clock high. The data line does not change at the rising edge. Each word is sent from bit 31 down to bit 0.
- R6: Each run produces exactly WORD_COUNT × 32 configuration-clock pulses, and the clock returns to 0 after the last one.
- R7: Busy stays 1 from the cycle after start is accepted until the last bit's high phase ends. It is 0 in the done cycle.
- R8: Done is a single-cycle pulse in the cycle right after the final high clock phase. In that cycle the clock is 0 and busy is 0.
- R9: A start that arrives while busy is ignored. The program line does not pulse again, the bit count is unchanged, and the loader stays idle after done.
- R10: Read enable is a one-cycle pulse. Each run reads addresses 0 to WORD_COUNT−1 in rising order, each exactly once. Read data is taken two cycles after the read enable is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to run the configuration sequence |
| rd_en_o | output | 1 | Memory read strobe |
| rd_addr_o | output | ADDR_W | Word address of the read |
| rd_data_i | input | WORD_W | Read data, valid one cycle after the strobe |
| pwr_en_o | output | 1 | Target power enable |
| prog_n_o | output | 1 | Active-low program line to the target |
| cfg_clk_o | output | 1 | Serial configuration clock |
| cfg_data_o | output | 1 | Serial configuration data |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse after the last bit |

## Verification
The embedded properties assume three things about the environment:
- The memory returns the addressed word exactly one cycle after the read strobe.
- Every delay parameter is at least one cycle.
- Start is a synchronous level.

The bench meets these assumptions with a memory model that registers data on the strobe edge and with small non-zero delay values. It changes start only on falling clock edges. In the second run, a start pulse is injected in the middle of the stream, which exercises the busy-ignore path without breaking the latency assumption.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PWR_WAIT,
    ST_PRE_PROG,
    ST_PROG_LOW,
    ST_FETCH,
    ST_LOAD,
    ST_STREAM
  } ldr_state_e;
endpackage

// File: rtl/cfg_delay_timer.sv
module cfg_delay_timer #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  // A loaded value N keeps the caller's state for exactly N cycles.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expire_o = (cnt_q == CNT_W'(1));

  // R3
  delay_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    load_i |-> (load_val_i != '0));
endmodule

// File: rtl/cfg_bit_serializer.sv
module cfg_bit_serializer #(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned IDX_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              stop_i,
  output logic              ser_clk_o,
  output logic              ser_data_o,
  output logic              prefetch_o,
  output logic              word_end_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);
  localparam logic [IDX_W-1:0] PREF_IDX = IDX_W'(WORD_W - 2);

  logic              active_q;
  logic              hi_q;
  logic [IDX_W-1:0]  idx_q;
  logic [WORD_W-2:0] sh_q;
  logic              clk_q;
  logic              dat_q;

  // Pulse at the edge that puts the last bit on the line.
  assign prefetch_o = active_q && hi_q && (idx_q == PREF_IDX);
  // High phase of the last bit: the next edge must load a word or stop.
  assign word_end_o = active_q && hi_q && (idx_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      hi_q     <= 1'b0;
      idx_q    <= '0;
      sh_q     <= '0;
      clk_q    <= 1'b0;
      dat_q    <= 1'b0;
    end else if (load_i) begin
      sh_q     <= word_i[WORD_W-2:0];
      dat_q    <= word_i[WORD_W-1];
      clk_q    <= 1'b0;
      hi_q     <= 1'b0;
      idx_q    <= '0;
      active_q <= 1'b1;
    end else if (active_q) begin
      if (!hi_q) begin
        clk_q <= 1'b1;
        hi_q  <= 1'b1;
      end else if (idx_q == LAST_IDX) begin
        if (stop_i) begin
          active_q <= 1'b0;
          hi_q     <= 1'b0;
          clk_q    <= 1'b0;
          dat_q    <= 1'b0;
        end
      end else begin
        clk_q <= 1'b0;
        hi_q  <= 1'b0;
        idx_q <= idx_q + 1'b1;
        dat_q <= sh_q[WORD_W-2];
        sh_q  <= sh_q << 1;
      end
    end
  end

  assign ser_clk_o  = clk_q;
  assign ser_data_o = dat_q;

  // R5
  data_setup_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ser_clk_o) |-> $stable(ser_data_o));
  // R5
  clk_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (ser_clk_o && !load_i && !(word_end_o && !stop_i)) |=> !ser_clk_o);
endmodule

// File: rtl/cfg_stream_loader.sv
module cfg_stream_loader
  import cfg_loader_pkg::*;
#(
  parameter int unsigned WORD_W       = 32,
  parameter int unsigned WORD_COUNT   = 10524,
  parameter int unsigned PWR_WAIT_CYC = 2400000,
  parameter int unsigned PRE_PROG_CYC = 48000,
  parameter int unsigned PROG_LOW_CYC = 2400000,
  localparam int unsigned ADDR_W  = (WORD_COUNT > 1) ? $clog2(WORD_COUNT) : 1,
  localparam int unsigned MAX_A   = (PWR_WAIT_CYC > PRE_PROG_CYC) ? PWR_WAIT_CYC : PRE_PROG_CYC,
  localparam int unsigned MAX_DLY = (MAX_A > PROG_LOW_CYC) ? MAX_A : PROG_LOW_CYC,
  localparam int unsigned DLY_W   = $clog2(MAX_DLY + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [WORD_W-1:0] rd_data_i,
  output logic              pwr_en_o,
  output logic              prog_n_o,
  output logic              cfg_clk_o,
  output logic              cfg_data_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(WORD_COUNT - 1);

  ldr_state_e        state_q;
  logic              tmr_load;
  logic [DLY_W-1:0]  tmr_val;
  logic              tmr_exp;
  logic              ser_load;
  logic              ser_stop;
  logic              ser_pref;
  logic              ser_end;
  logic              pend_q;
  logic [ADDR_W-1:0] addr_q;
  logic              rd_en_q;
  logic              pwr_q;
  logic              prog_n_q;
  logic              busy_q;
  logic              done_q;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state_q)
      ST_IDLE:     if (start_i) begin tmr_load = 1'b1; tmr_val = DLY_W'(PWR_WAIT_CYC); end
      ST_PWR_WAIT: if (tmr_exp) begin tmr_load = 1'b1; tmr_val = DLY_W'(PRE_PROG_CYC); end
      ST_PRE_PROG: if (tmr_exp) begin tmr_load = 1'b1; tmr_val = DLY_W'(PROG_LOW_CYC); end
      default: ;
    endcase
  end

  assign ser_load = (state_q == ST_LOAD) || ((state_q == ST_STREAM) && ser_end && pend_q);
  assign ser_stop = (state_q == ST_STREAM) && ser_end && !pend_q;

  cfg_delay_timer #(.CNT_W(DLY_W)) timer_i (
    .clk(clk), .rst(rst), .load_i(tmr_load), .load_val_i(tmr_val), .expire_o(tmr_exp)
  );

  cfg_bit_serializer #(.WORD_W(WORD_W)) ser_i (
    .clk(clk), .rst(rst), .load_i(ser_load), .word_i(rd_data_i), .stop_i(ser_stop),
    .ser_clk_o(cfg_clk_o), .ser_data_o(cfg_data_o),
    .prefetch_o(ser_pref), .word_end_o(ser_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      pwr_q    <= 1'b0;
      prog_n_q <= 1'b1;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      rd_en_q  <= 1'b0;
      addr_q   <= '0;
      pend_q   <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      rd_en_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          pwr_q   <= 1'b1;
          busy_q  <= 1'b1;
          state_q <= ST_PWR_WAIT;
        end
        ST_PWR_WAIT: if (tmr_exp) state_q <= ST_PRE_PROG;
        ST_PRE_PROG: if (tmr_exp) begin
          prog_n_q <= 1'b0;
          state_q  <= ST_PROG_LOW;
        end
        ST_PROG_LOW: if (tmr_exp) begin
          prog_n_q <= 1'b1;
          rd_en_q  <= 1'b1;
          addr_q   <= '0;
          pend_q   <= 1'b1;
          state_q  <= ST_FETCH;
        end
        ST_FETCH: state_q <= ST_LOAD;
        ST_LOAD: begin
          pend_q  <= 1'b0;
          state_q <= ST_STREAM;
        end
        ST_STREAM: begin
          if (ser_pref && (addr_q != LAST_ADDR)) begin
            rd_en_q <= 1'b1;
            addr_q  <= addr_q + 1'b1;
            pend_q  <= 1'b1;
          end
          if (ser_end) begin
            if (pend_q) begin
              pend_q <= 1'b0;
            end else begin
              busy_q  <= 1'b0;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_en_o   = rd_en_q;
  assign rd_addr_o = addr_q;
  assign pwr_en_o  = pwr_q;
  assign prog_n_o  = prog_n_q;
  assign busy_o    = busy_q;
  assign done_o    = done_q;

  // R4
  prog_low_clk_chk: assert property (@(posedge clk) disable iff (rst)
    !prog_n_o |-> !cfg_clk_o);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && !cfg_clk_o));
  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |=> pwr_en_o);
  // R10
  rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en_o |=> !rd_en_o);
endmodule

// File: tb/cfg_stream_loader_tb.sv
module cfg_stream_loader_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WW  = 32;
  localparam int NW  = 5;
  localparam int PWR = 20;
  localparam int PRE = 6;
  localparam int LOW = 15;
  localparam int AW  = $clog2(NW);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          rd_en;
  logic [AW-1:0] rd_addr;
  logic [WW-1:0] rd_data = '0;
  logic          pwr_en, prog_n, cfg_clk, cfg_data, busy, done;

  int errors = 0;
  int checks = 0;
  logic [31:0] seed = '0;
  bit   exp_q[$];
  int   bits_seen = 0;
  int   exp_addr = 0;
  logic prev_cclk = 1'b0;
  logic prev_data = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_stream_loader #(
    .WORD_W(WW), .WORD_COUNT(NW), .PWR_WAIT_CYC(PWR),
    .PRE_PROG_CYC(PRE), .PROG_LOW_CYC(LOW)
  ) dut_i (
    .clk(clk), .rst(rst), .start_i(start), .rd_en_o(rd_en), .rd_addr_o(rd_addr),
    .rd_data_i(rd_data), .pwr_en_o(pwr_en), .prog_n_o(prog_n), .cfg_clk_o(cfg_clk),
    .cfg_data_o(cfg_data), .busy_o(busy), .done_o(done)
  );

  function automatic logic [31:0] pattern(int a, logic [31:0] s);
    return s ^ (32'(a + 1) * 32'h9E3779B9);
  endfunction

  // memory model, one cycle of latency (R10)
  always @(posedge clk) if (rd_en) rd_data <= pattern(int'(rd_addr), seed);

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push_expect(logic [31:0] s);
    for (int w = 0; w < NW; w++) begin
      logic [31:0] v;
      v = pattern(w, s);
      for (int b = WW - 1; b >= 0; b--) exp_q.push_back(v[b]);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (cfg_clk && !prev_cclk) begin
        bit e;
        bits_seen++;
        check(cfg_data == prev_data, "R5", "data changed at rise", cfg_data, prev_data);
        if (exp_q.size() == 0) begin
          check(1'b0, "R6", "extra clock pulse", bits_seen, NW * WW);
        end else begin
          e = exp_q.pop_front();
          check(cfg_data == e, "R5", "serial bit", cfg_data, e);
        end
      end
      if (rd_en) begin
        check(int'(rd_addr) == exp_addr, "R10", "read address", rd_addr, exp_addr);
        exp_addr++;
      end
    end
    prev_cclk = cfg_clk;
    prev_data = cfg_data;
  end

  task automatic run(logic [31:0] s, bit mid_start);
    int n;
    bit bad;
    bit busy_drop;
    bit prog_bad;
    logic last_cclk;
    seed = s;
    exp_q.delete();
    push_expect(s);
    bits_seen = 0;
    exp_addr  = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(pwr_en == 1'b1, "R2", "power enable after start", pwr_en, 1);
    check(busy == 1'b1, "R7", "busy after start", busy, 1);
    n = 0; bad = 0;
    while (prog_n && n < 1000) begin
      if (cfg_clk || cfg_data || !pwr_en) bad = 1;
      @(negedge clk); n++;
    end
    check(n == PWR + PRE, "R3", "cycles to program fall", n, PWR + PRE);
    check(!bad, "R3", "lines quiet before program", bad, 0);
    n = 0; bad = 0;
    while (!prog_n && n < 1000) begin
      if (cfg_clk) bad = 1;
      @(negedge clk); n++;
    end
    check(n == LOW, "R4", "program low width", n, LOW);
    check(!bad, "R4", "clock low during program", bad, 0);
    if (mid_start) begin
      repeat (40) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    n = 0; busy_drop = 0; prog_bad = 0; last_cclk = 0;
    while (!done && n < 5000) begin
      if (!busy) busy_drop = 1;
      if (!prog_n) prog_bad = 1;
      last_cclk = cfg_clk;
      @(negedge clk); n++;
    end
    check(done == 1'b1, "R8", "done pulse seen", done, 1);
    check(!busy_drop, "R7", "busy held during stream", busy_drop, 0);
    check(!prog_bad, "R9", "no second program pulse", prog_bad, 0);
    check(busy == 1'b0, "R7", "busy low at done", busy, 0);
    check(last_cclk == 1'b1 && cfg_clk == 1'b0, "R8", "done after final high phase",
          {last_cclk, cfg_clk}, 2'b10);
    check(bits_seen == NW * WW, "R6", "clock pulse count", bits_seen, NW * WW);
    check(exp_q.size() == 0, "R6", "bits left in scoreboard", exp_q.size(), 0);
    check(exp_addr == NW, "R10", "reads per run", exp_addr, NW);
    @(negedge clk);
    check(done == 1'b0, "R8", "done lasts one cycle", done, 0);
    bad = 0;
    repeat (10) begin
      if (busy || !prog_n || cfg_clk || rd_en) bad = 1;
      @(negedge clk);
    end
    check(!bad, "R9", "idle after done", bad, 0);
    check(pwr_en == 1'b1, "R2", "power stays on", pwr_en, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(pwr_en == 0 && prog_n == 1 && cfg_clk == 0 && cfg_data == 0,
          "R1", "reset lines", {pwr_en, prog_n, cfg_clk, cfg_data}, 4'b0100);
    check(busy == 0 && done == 0 && rd_en == 0, "R1", "reset flags",
          {busy, done, rd_en}, 0);
    run(32'hA5A5_5A5A, 1'b0);
    run(32'hFFFF_0000, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule